// File: doc/BRIEF.md
# Arm Cell Insertion Selector

This block chooses, once per control period, which cells of one converter arm are switched into the current path. A start strobe captures the arm voltage reference, the signed arm current and the measured capacitor voltage of every cell. The block derives the number of cells to insert by rounding the reference against the mean of the measured voltages. It ranks all cells by voltage, with a direction set by the current sign. It then edits the present insertion pattern by only as many cells as the count has moved.

Each cell has a complementary gate pair. A per-cell driver inserts a guard interval with both gates off around every change. A trip input forces all gates off at once and keeps them off until an explicit clear. Selection keeps running while tripped, so the gates resume the latest pattern after the clear.

Top module: `cell_balance_selector`

## Requirements
- R1: A cell marked for insertion (ins_mask bit c = 1) is driven gate_hi=1, gate_lo=0; a bypassed cell is driven gate_hi=0, gate_lo=1; the two gates of a cell are never high together.
- R2: With S the sum of the captured cell voltages and N the cell count, ins_count becomes floor((2·arm_ref·N + S)/(2·S)), limited to N. This is the reference over the measured mean, rounded half up.
- R3: When S is zero, ins_count and ins_mask keep their previous values, and done still pulses.
- R4: Cells are ranked by voltage, highest first when arm_cur is greater than zero and lowest first otherwise; equal voltages rank the lower cell number first.
- R5: When the count rises, the extra cells are the first bypassed cells in rank order; when it falls, inserted cells are removed starting from the last-ranked; every other cell keeps its state.
- R6: done is a one-cycle pulse raised N+1 clock edges after the edge that samples start, with ins_mask and ins_count updated on that same edge; a start seen while an update is in progress is ignored, and the captured inputs are used throughout the update.
- R7: Every change of a cell's gate pair passes through at least dead_cyc+1 clock cycles with both gates low.
- R8: On the edge that samples trip high, all gates go low; they stay low until trip_clear is sampled, and updates still proceed while tripped.
- R9: During and right after reset, ins_mask and ins_count are zero, done is low and all gates are low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins one update when idle |
| arm_ref | input | RW | Arm voltage reference, same scale as cell voltages |
| arm_cur | input | IAW | Signed arm current, positive discharges inserted cells |
| v_cells | input | N_CELLS*VW | Measured cell voltages, cell c at bits c*VW upward |
| dead_cyc | input | DTW | Guard length in cycles minus one |
| trip | input | 1 | Forces all gates off and arms the latch |
| trip_clear | input | 1 | Releases the trip latch |
| gate_hi | output | N_CELLS | Upper switch gate per cell |
| gate_lo | output | N_CELLS | Lower switch gate per cell |
| ins_mask | output | N_CELLS | Latched insertion pattern |
| ins_count | output | $clog2(N_CELLS+1) | Latched number of inserted cells |
| done | output | 1 | Pulse when a new pattern is latched |

## Verification
The result of a start is due exactly N+1 edges later, so the driver counts falling-edge samples from the start strobe and requires done on the (N+2)th. At that same sample, the scoreboard monitor compares ins_mask and ins_count with the queued expectation. Gate outputs follow the new pattern at most dead_cyc+2 edges after done, and the bench samples them dead_cyc+4 falling edges later. Trip takes effect on the next sample. The guard interval is measured per cell as a run of consecutive low-low samples ending in a rise.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SORT = 2'd1,
      ST_PICK = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cbs_level_calc.sv
// Derives the inserted-cell count from the reference and the voltage sum.
module cbs_level_calc #(
   parameter int N_CELLS = 16,
   parameter int VW      = 16,
   parameter int RW      = 24
) (
   input  logic [N_CELLS*VW-1:0]          cell_v,
   input  logic [RW-1:0]                  ref_v,
   output logic [$clog2(N_CELLS+1)-1:0]   level,
   output logic                           level_ok
);
   localparam int CW   = $clog2(N_CELLS+1);
   localparam int SW   = VW + CW;
   localparam int NUMW = RW + CW + 2;

   logic [SW-1:0]   sum_v;
   logic [NUMW-1:0] num_v, den_v, quot_v;

   always_comb begin
      sum_v = '0;
      for (int c = 0; c < N_CELLS; c++) begin
         sum_v = sum_v + SW'(cell_v[c*VW +: VW]);
      end
   end

   always_comb begin
      num_v    = NUMW'(ref_v) * NUMW'(2 * N_CELLS) + NUMW'(sum_v);
      den_v    = NUMW'({sum_v, 1'b0});
      level_ok = (sum_v != '0);
      quot_v   = level_ok ? (num_v / den_v) : '0;
      if (quot_v > NUMW'(N_CELLS)) level = CW'(N_CELLS);
      else                         level = quot_v[CW-1:0];
   end
endmodule

// File: rtl/cbs_rank_sorter.sv
// Odd-even transposition ranking: one compare phase per step.
module cbs_rank_sorter #(
   parameter int N_CELLS = 16,
   parameter int VW      = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  load,
   input  logic                                  step,
   input  logic                                  odd_phase,
   input  logic                                  desc,
   input  logic                                  check_en,
   input  logic [N_CELLS*VW-1:0]                 cells_in,
   output logic [N_CELLS*VW-1:0]                 rank_val,
   output logic [N_CELLS*$clog2(N_CELLS)-1:0]    rank_idx
);
   localparam int IW = $clog2(N_CELLS);

   logic [VW-1:0] val_q [N_CELLS];
   logic [IW-1:0] idx_q [N_CELLS];
   logic [VW-1:0] val_d [N_CELLS];
   logic [IW-1:0] idx_d [N_CELLS];
   logic [N_CELLS-2:0] swap;

   function automatic logic goes_first(input logic [VW-1:0] va, input logic [IW-1:0] ia,
                                       input logic [VW-1:0] vb, input logic [IW-1:0] ib,
                                       input logic dsc);
      if (va == vb) return ia < ib;
      return dsc ? (va > vb) : (va < vb);
   endfunction

   for (genvar k = 0; k < N_CELLS-1; k++) begin : g_cmp
      assign swap[k] = step && (odd_phase == 1'(k % 2)) &&
                       goes_first(val_q[k+1], idx_q[k+1], val_q[k], idx_q[k], desc);

      a_r4_ranked: assert property (@(posedge clk) disable iff (!rst_n)
         check_en |-> goes_first(val_q[k], idx_q[k], val_q[k+1], idx_q[k+1], desc));
   end

   for (genvar i = 0; i < N_CELLS; i++) begin : g_elem
      logic          from_up, from_dn;
      logic [VW-1:0] up_v, dn_v;
      logic [IW-1:0] up_i, dn_i;
      if (i < N_CELLS-1) begin : g_up
         assign from_up = swap[i];
         assign up_v    = val_q[i+1];
         assign up_i    = idx_q[i+1];
      end else begin : g_noup
         assign from_up = 1'b0;
         assign up_v    = '0;
         assign up_i    = '0;
      end
      if (i > 0) begin : g_dn
         assign from_dn = swap[i-1];
         assign dn_v    = val_q[i-1];
         assign dn_i    = idx_q[i-1];
      end else begin : g_nodn
         assign from_dn = 1'b0;
         assign dn_v    = '0;
         assign dn_i    = '0;
      end
      assign val_d[i] = from_up ? up_v : (from_dn ? dn_v : val_q[i]);
      assign idx_d[i] = from_up ? up_i : (from_dn ? dn_i : idx_q[i]);
      assign rank_val[i*VW +: VW] = val_q[i];
      assign rank_idx[i*IW +: IW] = idx_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_CELLS; i++) begin
            val_q[i] <= '0;
            idx_q[i] <= IW'(i);
         end
      end else if (load) begin
         for (int i = 0; i < N_CELLS; i++) begin
            val_q[i] <= cells_in[i*VW +: VW];
            idx_q[i] <= IW'(i);
         end
      end else begin
         for (int i = 0; i < N_CELLS; i++) begin
            val_q[i] <= val_d[i];
            idx_q[i] <= idx_d[i];
         end
      end
   end
endmodule

// File: rtl/cbs_gate_pair.sv
// Complementary gate pair with a guard interval on every change.
module cbs_gate_pair #(
   parameter int DTW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           want_on,
   input  logic           force_off,
   input  logic [DTW-1:0] dead_len,
   output logic           gate_hi,
   output logic           gate_lo
);
   logic [DTW-1:0] wait_q;
   logic [DTW:0]   off_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
         wait_q  <= '0;
      end else if (force_off || (gate_hi && !want_on) || (gate_lo && want_on)) begin
         gate_hi <= 1'b0;
         gate_lo <= 1'b0;
         wait_q  <= '0;
      end else if (!gate_hi && !gate_lo) begin
         if (wait_q >= dead_len) begin
            gate_hi <= want_on;
            gate_lo <= !want_on;
            wait_q  <= '0;
         end else begin
            wait_q  <= wait_q + 1'b1;
         end
      end
   end

   // checker: length of the current both-off run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   off_run_q <= '0;
      else if (gate_hi || gate_lo)  off_run_q <= '0;
      else if (off_run_q != '1)     off_run_q <= off_run_q + 1'b1;
   end

   a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   a_r7_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run_q > {1'b0, dead_len}));
endmodule

// File: rtl/cell_balance_selector.sv
module cell_balance_selector
   import cbs_pkg::*;
#(
   parameter int N_CELLS = 16,
   parameter int VW      = 16,
   parameter int RW      = 24,
   parameter int IAW     = 16,
   parameter int DTW     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [RW-1:0]                 arm_ref,
   input  logic signed [IAW-1:0]         arm_cur,
   input  logic [N_CELLS*VW-1:0]         v_cells,
   input  logic [DTW-1:0]                dead_cyc,
   input  logic                          trip,
   input  logic                          trip_clear,
   output logic [N_CELLS-1:0]            gate_hi,
   output logic [N_CELLS-1:0]            gate_lo,
   output logic [N_CELLS-1:0]            ins_mask,
   output logic [$clog2(N_CELLS+1)-1:0]  ins_count,
   output logic                          done
);
   localparam int IW = $clog2(N_CELLS);
   localparam int CW = $clog2(N_CELLS+1);

   if (N_CELLS < 2) begin : g_bad_n
      $error("N_CELLS must be at least 2");
   end
   if (RW < VW) begin : g_bad_rw
      $error("RW must not be narrower than VW");
   end

   seq_state_e         state_q;
   logic [CW-1:0]      pass_q;
   logic [RW-1:0]      ref_q;
   logic               desc_q;
   logic [N_CELLS-1:0] mask_q, pick_mask;
   logic [CW-1:0]      cnt_q, lvl, lvl_use, need, tally;
   logic               lvl_ok, done_q, trip_q, trip_any;
   logic [N_CELLS*VW-1:0] rank_val;
   logic [N_CELLS*IW-1:0] rank_idx;
   logic [IW-1:0]      sel;

   cbs_rank_sorter #(.N_CELLS(N_CELLS), .VW(VW)) u_sort (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (state_q == ST_IDLE && start),
      .step      (state_q == ST_SORT),
      .odd_phase (pass_q[0]),
      .desc      (desc_q),
      .check_en  (state_q == ST_PICK),
      .cells_in  (v_cells),
      .rank_val  (rank_val),
      .rank_idx  (rank_idx)
   );

   cbs_level_calc #(.N_CELLS(N_CELLS), .VW(VW), .RW(RW)) u_level (
      .cell_v   (rank_val),
      .ref_v    (ref_q),
      .level    (lvl),
      .level_ok (lvl_ok)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= '0;
         ref_q   <= '0;
         desc_q  <= 1'b0;
         mask_q  <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               ref_q   <= arm_ref;
               desc_q  <= (arm_cur > 0);
               pass_q  <= '0;
               state_q <= ST_SORT;
            end
            ST_SORT: begin
               if (pass_q == CW'(N_CELLS-1)) state_q <= ST_PICK;
               else                          pass_q  <= pass_q + 1'b1;
            end
            ST_PICK: begin
               mask_q  <= pick_mask;
               cnt_q   <= lvl_use;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // incremental selection from the ranked list
   always_comb begin
      lvl_use   = lvl_ok ? lvl : cnt_q;
      pick_mask = mask_q;
      tally     = '0;
      need      = '0;
      sel       = '0;
      if (lvl_use > cnt_q) begin
         need = lvl_use - cnt_q;
         for (int k = 0; k < N_CELLS; k++) begin
            sel = rank_idx[k*IW +: IW];
            if (!pick_mask[sel] && tally < need) begin
               pick_mask[sel] = 1'b1;
               tally          = tally + 1'b1;
            end
         end
      end else if (lvl_use < cnt_q) begin
         need = cnt_q - lvl_use;
         for (int k = N_CELLS-1; k >= 0; k--) begin
            sel = rank_idx[k*IW +: IW];
            if (pick_mask[sel] && tally < need) begin
               pick_mask[sel] = 1'b0;
               tally          = tally + 1'b1;
            end
         end
      end
   end

   // trip latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trip_q <= 1'b0;
      else if (trip)       trip_q <= 1'b1;
      else if (trip_clear) trip_q <= 1'b0;
   end
   assign trip_any = trip || trip_q;

   for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
      cbs_gate_pair #(.DTW(DTW)) u_pair (
         .clk       (clk),
         .rst_n     (rst_n),
         .want_on   (mask_q[c]),
         .force_off (trip_any),
         .dead_len  (dead_cyc),
         .gate_hi   (gate_hi[c]),
         .gate_lo   (gate_lo[c])
      );
   end

   assign ins_mask  = mask_q;
   assign ins_count = cnt_q;
   assign done      = done_q;

   a_r2_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(N_CELLS));

   a_r5_mask_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mask_q) == int'(cnt_q));

   a_r3_zero_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PICK && !lvl_ok) |=> ($stable(mask_q) && $stable(cnt_q)));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(ins_mask) && $stable(ins_count)));

   a_r8_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
      (trip || trip_q) |=> (gate_hi == '0 && gate_lo == '0));
endmodule

// File: tb/test_cell_balance_selector.sv
`timescale 1ns/1ps
module test_cell_balance_selector;
   localparam int N   = 16;
   localparam int VW  = 16;
   localparam int RW  = 24;
   localparam int IAW = 16;
   localparam int DTW = 8;
   localparam int CW  = $clog2(N+1);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, trip = 1'b0, trip_clear = 1'b0;
   logic [RW-1:0]         arm_ref = '0;
   logic signed [IAW-1:0] arm_cur = '0;
   logic [N*VW-1:0]       v_cells = '0;
   logic [DTW-1:0]        dead_cyc = 8'd3;
   logic [N-1:0]          gate_hi, gate_lo, ins_mask;
   logic [CW-1:0]         ins_count;
   logic                  done;

   always #2.5 clk = ~clk;

   cell_balance_selector #(.N_CELLS(N), .VW(VW), .RW(RW), .IAW(IAW), .DTW(DTW)) i_cell_balance_selector (
      .clk(clk), .rst_n(rst_n), .start(start), .arm_ref(arm_ref), .arm_cur(arm_cur),
      .v_cells(v_cells), .dead_cyc(dead_cyc), .trip(trip), .trip_clear(trip_clear),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .ins_mask(ins_mask), .ins_count(ins_count), .done(done)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   bit tripped = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct { logic [N-1:0] mask; int cnt; } exp_t;
   exp_t sb[$];

   logic [N-1:0] m_mask = '0;
   int m_cnt = 0;
   int vlt [N];

   // expectation from the requirements (R2..R5)
   task automatic model_push(input longint refv, input bit pos);
      longint s;
      int ord [N];
      bit used [N];
      int lvl, need;
      s = 0;
      for (int i = 0; i < N; i++) begin s += vlt[i]; used[i] = 0; end
      if (s == 0) lvl = m_cnt;
      else begin
         longint q;
         q = (2 * refv * N + s) / (2 * s);
         lvl = (q > N) ? N : int'(q);
      end
      for (int k = 0; k < N; k++) begin
         int b;
         b = -1;
         for (int j = 0; j < N; j++) begin
            if (!used[j]) begin
               if (b < 0) b = j;
               else if (pos ? (vlt[j] > vlt[b]) : (vlt[j] < vlt[b])) b = j;
            end
         end
         used[b] = 1;
         ord[k] = b;
      end
      if (lvl > m_cnt) begin
         need = lvl - m_cnt;
         for (int k = 0; k < N; k++)
            if (need > 0 && !m_mask[ord[k]]) begin m_mask[ord[k]] = 1'b1; need--; end
      end else if (lvl < m_cnt) begin
         need = m_cnt - lvl;
         for (int k = N-1; k >= 0; k--)
            if (need > 0 && m_mask[ord[k]]) begin m_mask[ord[k]] = 1'b0; need--; end
      end
      m_cnt = lvl;
      sb.push_back('{m_mask, m_cnt});
   endtask

   task automatic set_cells();
      for (int i = 0; i < N; i++) v_cells[i*VW +: VW] = VW'(vlt[i]);
   endtask

   task automatic check_gates(input string req);
      if (tripped) begin
         check(gate_hi == '0 && gate_lo == '0, req, "gates off while tripped", {gate_hi, gate_lo}, 0);
      end else begin
         check(gate_hi == m_mask,  req, "upper gates", gate_hi, m_mask);
         check(gate_lo == ~m_mask, req, "lower gates", gate_lo, ~m_mask);
      end
   endtask

   // called at a falling edge
   task automatic run_update(input longint refv, input int cur, input bit poke);
      int k;
      model_push(refv, cur > 0);
      set_cells();
      arm_ref = RW'(refv);
      arm_cur = IAW'(cur);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 1;
      while (!done && k < 100) begin
         if (poke && k == 3) begin start = 1'b1; arm_ref = '0; arm_cur = -IAW'(cur); end
         else start = 1'b0;
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      check(k == N + 2, "R6", "done latency in samples", k, N + 2);
      repeat (int'(dead_cyc) + 4) @(negedge clk);
      check(sb.size() == 0, "R6", "pending results", sb.size(), 0);
      check_gates("R1");
   endtask

   // scoreboard monitor (R2, R5)
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) check(1'b0, "R6", "unexpected done", 1, 0);
         else begin
            exp_t e;
            e = sb.pop_front();
            check(ins_mask == e.mask, "R5", "insertion vector", ins_mask, e.mask);
            check(int'(ins_count) == e.cnt, "R2", "inserted count", ins_count, e.cnt);
         end
      end
   end

   // guard interval and overlap monitor (R1, R7)
   int offrun [N];
   initial for (int c = 0; c < N; c++) offrun[c] = 0;
   always @(negedge clk) begin
      for (int c = 0; c < N; c++) begin
         if (gate_hi[c] && gate_lo[c]) check(1'b0, "R1", "both gates high", c, -1);
         if (!gate_hi[c] && !gate_lo[c]) offrun[c]++;
         else begin
            if (offrun[c] > 0)
               check(offrun[c] >= int'(dead_cyc) + 1, "R7", "guard length", offrun[c], int'(dead_cyc) + 1);
            offrun[c] = 0;
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "WD", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) vlt[i] = 0;
      repeat (4) @(negedge clk);
      // R9 reset state
      check(ins_mask == '0 && ins_count == '0, "R9", "outputs in reset", {ins_mask, ins_count}, 0);
      check(done == 1'b0, "R9", "done in reset", done, 0);
      check(gate_hi == '0 && gate_lo == '0, "R9", "gates in reset", {gate_hi, gate_lo}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ins_count == '0, "R9", "count after reset", ins_count, 0);
      repeat (int'(dead_cyc) + 4) @(negedge clk);
      check_gates("R1");

      // R2/R5 equal cells, add from empty (ties by index, R4)
      for (int i = 0; i < N; i++) vlt[i] = 1000;
      run_update(8000, 100, 0);
      // R4 rising voltages, discharge order, remove from tail (R5)
      for (int i = 0; i < N; i++) vlt[i] = 1000 + 10 * i;
      run_update(5375, 50, 0);
      // R4 charging order, count rises (R5)
      run_update(10750, -50, 0);
      // R2 rounding below and at half
      for (int i = 0; i < N; i++) vlt[i] = 1000;
      run_update(2499, 1, 0);
      run_update(2500, -1, 0);
      // R2 clamp high then zero reference
      run_update(40000, 1, 0);
      run_update(0, 1, 0);
      // R3 zero sum keeps state
      run_update(6000, 1, 0);
      for (int i = 0; i < N; i++) vlt[i] = 0;
      run_update(9000, 1, 0);
      // R4 grouped ties, zero current ranks lowest first
      for (int i = 0; i < N; i++) vlt[i] = 1200 - 50 * (i / 4);
      run_update(11000, 0, 0);
      run_update(3000, 0, 0);
      // R6 second start during update is ignored
      for (int i = 0; i < N; i++) vlt[i] = 900 + 7 * ((i * 5) % N);
      run_update(7000, 20, 1);
      // R7 zero-length guard
      dead_cyc = 8'd0;
      run_update(12000, -20, 0);
      run_update(4000, 20, 0);
      dead_cyc = 8'd3;
      // R8 trip, update while tripped, release
      trip = 1'b1;
      @(negedge clk);
      trip = 1'b0;
      tripped = 1;
      check(gate_hi == '0 && gate_lo == '0, "R8", "gates after trip", {gate_hi, gate_lo}, 0);
      run_update(9000, 20, 0);
      repeat (20) @(negedge clk);
      check_gates("R8");
      trip_clear = 1'b1;
      @(negedge clk);
      trip_clear = 1'b0;
      tripped = 0;
      repeat (int'(dead_cyc) + 6) @(negedge clk);
      check_gates("R8");

      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R6", "leftover results", sb.size(), 0);
      finish_run();
   end
endmodule